// File: doc/BRIEF.md
# LIN-aware UART checksum accumulator

This block keeps two independent 8-bit running checksums next to a UART that can also run as a LIN node: one over the bytes the receiver delivers and one over the bytes the transmitter sends. Each channel presents a byte-valid strobe, the byte, and a flag that marks the byte as the frame's protected identifier. The sums use end-around carry: a carry out of the top bit is added back into the result. The stored value is the raw folded sum. Any inversion for the bus is done elsewhere.

Three shared inputs control the sums. The first selects LIN or plain UART operation. The second is an enable bit whose meaning depends on that mode. In LIN mode it chooses whether the identifier byte is counted; in plain UART mode it chooses whether the sums accumulate at all. The third is a break-detected pulse, which clears both sums in LIN mode. Software sees both sums packed into one 32-bit word. It can overwrite either field through a per-field write strobe.

Top module: `lin_chk_accum`

## Requirements
- R1: After a synchronous reset both sums are 0, so the read word is 0x00000000.
- R2: The read word carries the receive sum in bits 23:16 and the transmit sum in bits 7:0; bits 31:24 and 15:8 always read 0.
- R3: An accepted byte is added to its sum modulo 256, and a carry out of bit 7 is added back (0xFF + 0x01 gives 0x01); a nonzero sum never becomes 0 through an addition.
- R4: In LIN mode (lin_mode=1) with pid_incl=1, a byte flagged as identifier is added like a data byte.
- R5: In LIN mode with pid_incl=0, a byte flagged as identifier leaves its sum unchanged, while data bytes are still added.
- R6: In LIN mode, brk_pulse clears both sums to 0 on the next clock edge, and takes priority over a software write and a byte in the same cycle.
- R7: In plain UART mode (lin_mode=0) with pid_incl=1, every valid byte is added, and the identifier flag is ignored.
- R8: In plain UART mode with pid_incl=0, both sums hold their value whatever bytes arrive.
- R9: sw_we bit 0 loads the transmit sum from sw_wdata[7:0], and sw_we bit 1 loads the receive sum from sw_wdata[23:16]. A write wins over a byte update to the same field in the same cycle.
- R10: The receive and transmit sums update independently, and both may take a byte in the same cycle.
- R11: In plain UART mode brk_pulse has no effect on either sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lin_mode | input | 1 | 1 = LIN operation, 0 = plain UART |
| pid_incl | input | 1 | LIN: count identifier bytes; UART: accumulate enable |
| brk_pulse | input | 1 | Break detected (acts in LIN mode only) |
| rx_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_is_pid | input | 1 | Received byte is the identifier |
| tx_vld | input | 1 | Transmitted byte valid |
| tx_byte | input | 8 | Transmitted byte |
| tx_is_pid | input | 1 | Transmitted byte is the identifier |
| sw_we | input | 2 | Field write strobes: bit 0 transmit, bit 1 receive |
| sw_wdata | input | 32 | Write data in the read-word layout |
| sw_rdata | output | 32 | Packed checksum word |

## Verification
The hardest situation to reach is a single cycle in which a break, a software write and an identifier byte all arrive while the mode and enable bit also change. Only that cycle exercises the priority order and the mode-dependent meaning of the enable bit together. Directed steps set up each of these collisions on purpose. A long random phase then draws sparse break and write strobes, frequent bytes and a randomly toggled mode, and checks every cycle against a bench model. Directed steps also start the sums at 0xFF, so the end-around carry is exercised on both channels.

// File: rtl/chk_pkg.sv
package chk_pkg;
    localparam int CHK_W  = 8;
    localparam int REG_W  = 32;
    localparam int RX_LSB = 16;
    localparam int TX_LSB = 0;
    localparam int NLANE  = 2;
    localparam int LANE_TX = 0;
    localparam int LANE_RX = 1;

    typedef logic [CHK_W-1:0] chk_t;

    typedef struct packed {
        logic vld;
        chk_t data;
        logic is_pid;
    } byte_ev_t;

    typedef struct packed {
        logic lin_mode;
        logic pid_incl;
        logic brk;
    } chk_ctl_t;

    function automatic chk_t fold_add(input chk_t a, input chk_t b);
        logic [CHK_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CHK_W-1:0] + chk_t'(s[CHK_W]);
    endfunction
endpackage

// File: rtl/chk_lane.sv
module chk_lane
    import chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chk_ctl_t ctl,
    input  byte_ev_t ev,
    input  logic     wr,
    input  chk_t     wdata,
    output chk_t     sum
);
    logic take;
    logic clr;

    always_comb begin
        clr  = ctl.lin_mode && ctl.brk;
        take = ev.vld && (ctl.lin_mode ? (ctl.pid_incl || !ev.is_pid) : ctl.pid_incl);
    end

    always_ff @(posedge clk) begin
        if (rst)       sum <= '0;
        else if (clr)  sum <= '0;
        else if (wr)   sum <= wdata;
        else if (take) sum <= fold_add(sum, ev.data);
    end

    assert_brk_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.lin_mode && ctl.brk) |=> (sum == '0));
    assert_uart_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.lin_mode && !ctl.pid_incl && !wr) |=> $stable(sum));
    assert_uart_brk_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctl.lin_mode && ctl.brk && !wr && !ev.vld) |=> $stable(sum));
    assert_pid_skip_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.lin_mode && !ctl.pid_incl && !ctl.brk && !wr && ev.is_pid) |=> $stable(sum));
    assert_wr_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && !(ctl.lin_mode && ctl.brk)) |=> (sum == $past(wdata)));
    assert_no_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.vld && sum != '0 && !wr && !(ctl.lin_mode && ctl.brk)) |=> (sum != '0));
endmodule

// File: rtl/chk_pack.sv
module chk_pack
    import chk_pkg::*;
(
    input  chk_t              rx_sum,
    input  chk_t              tx_sum,
    output logic [REG_W-1:0]  word
);
    always_comb begin
        word = '0;
        word[RX_LSB +: CHK_W] = rx_sum;
        word[TX_LSB +: CHK_W] = tx_sum;
    end
endmodule

// File: rtl/lin_chk_accum.sv
module lin_chk_accum
    import chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lin_mode,
    input  logic              pid_incl,
    input  logic              brk_pulse,
    input  logic              rx_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_is_pid,
    input  logic              tx_vld,
    input  logic [7:0]        tx_byte,
    input  logic              tx_is_pid,
    input  logic [1:0]        sw_we,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata
);
    chk_ctl_t ctl;
    byte_ev_t ev   [NLANE];
    chk_t     wval [NLANE];
    chk_t     sums [NLANE];

    always_comb begin
        ctl = '{lin_mode: lin_mode, pid_incl: pid_incl, brk: brk_pulse};
        ev[LANE_TX]   = '{vld: tx_vld, data: tx_byte, is_pid: tx_is_pid};
        ev[LANE_RX]   = '{vld: rx_vld, data: rx_byte, is_pid: rx_is_pid};
        wval[LANE_TX] = sw_wdata[TX_LSB +: CHK_W];
        wval[LANE_RX] = sw_wdata[RX_LSB +: CHK_W];
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        chk_lane u_lane (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .ev    (ev[g]),
            .wr    (sw_we[g]),
            .wdata (wval[g]),
            .sum   (sums[g])
        );
    end

    chk_pack u_pack (
        .rx_sum (sums[LANE_RX]),
        .tx_sum (sums[LANE_TX]),
        .word   (sw_rdata)
    );

    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (sw_rdata[31:24] == 8'h00) && (sw_rdata[15:8] == 8'h00));
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (sw_rdata == 32'h0));
endmodule

// File: tb/test_lin_chk_accum.sv
`timescale 1ns/1ps
module test_lin_chk_accum;
    logic clk = 0, rst = 1;
    logic lin_mode = 0, pid_incl = 0, brk_pulse = 0;
    logic rx_vld = 0, rx_is_pid = 0, tx_vld = 0, tx_is_pid = 0;
    logic [7:0] rx_byte = 0, tx_byte = 0;
    logic [1:0] sw_we = 0;
    logic [31:0] sw_wdata = 0, sw_rdata;
    int errors = 0, checks = 0;
    logic [7:0] m_rx = 0, m_tx = 0;

    always #2 clk = ~clk;

    lin_chk_accum i_lin_chk_accum (.*);

    function automatic logic [7:0] fold(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] cur, input logic lin, input logic en,
                                       input logic brk, input logic v, input logic [7:0] d,
                                       input logic p, input logic w, input logic [7:0] wd);
        if (lin && brk) return 8'h00;
        if (w) return wd;
        if (v && (lin ? (en || !p) : en)) return fold(cur, d);
        return cur;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // called at a negedge; returns at the following negedge after checking
    task automatic step(input logic lin, input logic en, input logic brk,
                        input logic rv, input logic [7:0] rd, input logic rp,
                        input logic tv, input logic [7:0] td, input logic tp,
                        input logic [1:0] we, input logic [31:0] wd, input string tag);
        lin_mode = lin; pid_incl = en; brk_pulse = brk;
        rx_vld = rv; rx_byte = rd; rx_is_pid = rp;
        tx_vld = tv; tx_byte = td; tx_is_pid = tp;
        sw_we = we; sw_wdata = wd;
        m_rx = nxt(m_rx, lin, en, brk, rv, rd, rp, we[1], wd[23:16]);
        m_tx = nxt(m_tx, lin, en, brk, tv, td, tp, we[0], wd[7:0]);
        @(posedge clk);
        @(negedge clk);
        check(sw_rdata, {8'h00, m_rx, 8'h00, m_tx}, tag);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        check(sw_rdata, 32'h0, "R1 reset value");
        // R9 / R2: software write to both fields
        step(1,1,0, 0,0,0, 0,0,0, 2'b11, 32'hFFA5FF3C, "R9 write both");
        check(sw_rdata, 32'h00A5003C, "R2 field layout");
        // R4: LIN include pid, 0x80 pid + 0x90 data -> 0x11
        step(1,1,0, 0,0,0, 0,0,0, 2'b11, 32'h0, "R9 clear");
        step(1,1,0, 1,8'h80,1, 1,8'h80,1, 2'b00, 32'h0, "R4 pid included");
        step(1,1,0, 1,8'h90,0, 1,8'h90,0, 2'b00, 32'h0, "R4 data after pid");
        check(sw_rdata, 32'h00110011, "R4 carry folded result");
        // R3: 0xFF + 0x01 -> 0x01
        step(1,1,0, 0,0,0, 0,0,0, 2'b11, 32'h00FF00FF, "R9 preload FF");
        step(1,1,0, 1,8'h01,0, 1,8'h01,0, 2'b00, 32'h0, "R3 end-around");
        check(sw_rdata, 32'h00010001, "R3 FF plus 01");
        // R5: LIN exclude pid
        step(1,0,0, 1,8'h33,1, 1,8'h44,1, 2'b00, 32'h0, "R5 pid skipped");
        check(sw_rdata, 32'h00010001, "R5 unchanged by pid");
        step(1,0,0, 1,8'h10,0, 1,8'h20,0, 2'b00, 32'h0, "R5 data counted");
        // R6: break beats write and byte
        step(1,1,1, 1,8'h55,0, 1,8'h66,0, 2'b11, 32'h00770077, "R6 break priority");
        check(sw_rdata, 32'h0, "R6 break clears both");
        // R7: plain UART, enable set, pid flag ignored
        step(0,1,0, 1,8'h12,1, 1,8'h34,1, 2'b00, 32'h0, "R7 uart accumulate");
        check(sw_rdata, 32'h00120034, "R7 pid flag ignored");
        // R8 hold, R11 break ignored
        step(0,0,0, 1,8'hAA,0, 1,8'hBB,0, 2'b00, 32'h0, "R8 uart hold");
        step(0,0,1, 0,0,0, 0,0,0, 2'b00, 32'h0, "R11 break no effect");
        step(0,1,1, 1,8'h01,0, 0,0,0, 2'b00, 32'h0, "R11 break while summing");
        check(sw_rdata, 32'h00130034, "R11 value kept");
        // R9 write wins over byte; R10 independent lanes
        step(0,1,0, 1,8'h05,0, 1,8'h05,0, 2'b01, 32'h00000009, "R9 write beats byte");
        check(sw_rdata, 32'h00180009, "R10 rx adds while tx written");
        for (int i = 0; i < 3000; i++) begin
            logic l = 1'($urandom);
            logic e = 1'($urandom);
            logic b = ($urandom % 16) == 0;
            logic [1:0] w = {($urandom % 10) == 0, ($urandom % 10) == 0};
            step(l, e, b, 1'($urandom), 8'($urandom), ($urandom % 4) == 0,
                 1'($urandom), 8'($urandom), ($urandom % 4) == 0, w, $urandom,
                 "R3 R10 random");
        end
        rst = 1;
        @(posedge clk); @(negedge clk);
        check(sw_rdata, 32'h0, "R1 reset after traffic");
        finish_run();
    end
endmodule